// File: doc/BRIEF.md
# Firmware Hub Single-Byte Read Target

This block is the target end of a 4-bit multiplexed firmware-hub bus and serves single-byte reads only. It samples a nibble-wide bus and an active-low frame strobe on every rising clock edge. It recognises a read start code and matches an ID-select nibble against its strapped ID. It then gathers a 28-bit address and a size code. When the transfer is accepted, it handles the turnaround, drives a ready sync nibble, returns one byte from a synchronous memory port and hands the bus back.

The shared bus is modelled as three separate signals: the sampled input nibble, the driven output nibble and an output enable. The byte comes from a memory port that is read for one cycle. The memory returns the data on the clock edge that follows that cycle.

Clock numbering below counts the edge that samples the start nibble as clock 1. An output written "in clock N" is the value present between edge N-1 and edge N, so the host samples it at edge N.

Top module: `fhr_read_target`

## Requirements
- R1: While the frame strobe is low, every sampled nibble replaces the pending start code. Only the nibble sampled at the last low edge before the strobe rises counts, so a trailing 1101 starts a read even after other nibbles, and a trailing non-1101 nibble cancels an earlier 1101.
- R2: A start code other than 1101 starts no read. The block never asserts `bus_oe` or `mem_rd` for that cycle.
- R3: The first nibble sampled with the strobe high after a start is the ID select. A read proceeds only if it equals `id_strap`; otherwise the block returns to idle without driving.
- R4: The next seven nibbles form the 28-bit address, most-significant nibble first, and it appears on `mem_addr`.
- R5: The nibble after the address is the size code. Only 0000 (one byte) is accepted; any other value returns the block to idle with no memory read and no drive.
- R6: `mem_rd` is high for exactly one cycle, clock 11, right after the size code is sampled. The byte on `mem_rdata` is captured at the following edge.
- R7: `bus_oe` first rises in clock 12, the second turnaround clock, with `bus_out` = 1111.
- R8: In clock 13 the block drives sync 0000. In clock 14 it drives the low nibble of the byte, and in clock 15 the high nibble.
- R9: In clock 16 the block drives 1111. `bus_oe` is low from clock 17, so a read takes 17 clocks and a new start may be sampled at edge 17.
- R10: A low frame strobe at any edge in the middle of a cycle abandons that cycle. Output enable drops in the next clock, and the nibble is taken as a fresh start field.
- R11: `bus_oe` is low out of reset and outside the clock 12 to clock 16 window of an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n | input | 1 | Active-low frame strobe from the host |
| bus_in | input | 4 | Nibble sampled from the shared bus |
| bus_out | output | 4 | Nibble driven onto the bus while enabled |
| bus_oe | output | 1 | Output enable for the bus drivers |
| id_strap | input | 4 | Strapped device ID compared with the ID select |
| mem_rd | output | 1 | One-cycle read request to the memory port |
| mem_addr | output | 28 | Read address assembled from the bus |
| mem_rdata | input | 8 | Memory data, valid the cycle after `mem_rd` |

## Verification
The assertions assume that the memory returns the addressed byte exactly one edge after `mem_rd`, and that the host floats or drives 1111 while the target owns the bus. They also assume that a low strobe is always a deliberate new start, so every check of the driving window is conditioned on the strobe being high. The bench models the memory as a register loaded when `mem_rd` is high. Its host drives 1111 with the strobe high during every target-owned clock. It asserts the strobe mid-cycle only to exercise abandonment, and it always pairs that with 1101 so that a fresh read follows.

// File: rtl/fhr_pkg.sv
// Package: shared constants and the phase type for the firmware-hub read target.
// Assumes a 4-bit bus nibble and a byte-wide data path.
package fhr_pkg;
    localparam int NIB_W  = 4;
    localparam int DATA_W = 8;

    localparam logic [NIB_W-1:0] CODE_START_RD = 4'b1101;
    localparam logic [NIB_W-1:0] CODE_SIZE_ONE = 4'b0000;
    localparam logic [NIB_W-1:0] CODE_READY    = 4'b0000;
    localparam logic [NIB_W-1:0] CODE_ONES     = 4'b1111;

    // Phase of the current bus clock as seen by the target.
    typedef enum logic [3:0] {
        PH_IDLE,
        PH_ARMED,
        PH_ADDR,
        PH_SIZE,
        PH_HTAR,
        PH_TTAR,
        PH_SYNC,
        PH_DLO,
        PH_DHI,
        PH_TEND
    } phase_t;
endpackage

// File: rtl/fhr_addr_shift.sv
// Module: collects the address nibbles, most-significant first.
// Assumes ADDR_W is a multiple of the nibble width. While shift_en is high,
// each edge shifts in one nibble. The count restarts whenever shift_en is low.
module fhr_addr_shift #(
    parameter int ADDR_W = 28
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      shift_en,
    input  logic [fhr_pkg::NIB_W-1:0] nib,
    output logic [ADDR_W-1:0]         addr,
    output logic                      addr_last
);
    localparam int NIBS  = ADDR_W / fhr_pkg::NIB_W;
    localparam int CNT_W = (NIBS > 1) ? $clog2(NIBS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NIBS - 1);

    logic [CNT_W-1:0] cnt;

    // Shift register holding the address, oldest nibble at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (shift_en)
            addr <= {addr[ADDR_W-fhr_pkg::NIB_W-1:0], nib};
    end

    // Counts the nibbles taken in the current address field.
    always_ff @(posedge clk) begin
        if (!rst_n || !shift_en)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // High on the edge that takes the final address nibble.
    assign addr_last = shift_en && (cnt == LAST);
endmodule

// File: rtl/fhr_seq.sv
// Module: field sequencer of the read target.
// Assumes the host holds the strobe low only during start fields. A low
// strobe at any edge restarts start detection from that nibble.
module fhr_seq (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      frame_n,
    input  logic [fhr_pkg::NIB_W-1:0] nib,
    input  logic [fhr_pkg::NIB_W-1:0] id_strap,
    input  logic                      addr_last,
    output fhr_pkg::phase_t           phase,
    output logic                      addr_shift_en
);
    import fhr_pkg::*;

    // Advances the phase one bus clock at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else if (!frame_n) begin
            phase <= (nib == CODE_START_RD) ? PH_ARMED : PH_IDLE;
        end else begin
            unique case (phase)
                PH_ARMED: phase <= (nib == id_strap) ? PH_ADDR : PH_IDLE;
                PH_ADDR:  if (addr_last) phase <= PH_SIZE;
                PH_SIZE:  phase <= (nib == CODE_SIZE_ONE) ? PH_HTAR : PH_IDLE;
                PH_HTAR:  phase <= PH_TTAR;
                PH_TTAR:  phase <= PH_SYNC;
                PH_SYNC:  phase <= PH_DLO;
                PH_DLO:   phase <= PH_DHI;
                PH_DHI:   phase <= PH_TEND;
                default:  phase <= PH_IDLE;
            endcase
        end
    end

    // Address nibbles are taken only in the address phase with the strobe high.
    assign addr_shift_en = frame_n && (phase == PH_ADDR);
endmodule

// File: rtl/fhr_drive.sv
// Module: captures the read byte and drives the target side of the bus.
// Assumes memory data is valid during the second turnaround clock.
module fhr_drive (
    input  logic                       clk,
    input  logic                       rst_n,
    input  fhr_pkg::phase_t            phase,
    input  logic [fhr_pkg::DATA_W-1:0] mem_rdata,
    output logic [fhr_pkg::NIB_W-1:0]  bus_out,
    output logic                       bus_oe
);
    import fhr_pkg::*;

    logic [DATA_W-1:0] data_q;

    // Holds the memory byte from the end of the second turnaround clock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (phase == PH_TTAR)
            data_q <= mem_rdata;
    end

    // Chooses the driven nibble and the enable for the current phase.
    always_comb begin
        bus_oe  = 1'b1;
        bus_out = CODE_ONES;
        unique case (phase)
            PH_TTAR: bus_out = CODE_ONES;
            PH_SYNC: bus_out = CODE_READY;
            PH_DLO:  bus_out = data_q[NIB_W-1:0];
            PH_DHI:  bus_out = data_q[DATA_W-1:NIB_W];
            PH_TEND: bus_out = CODE_ONES;
            default: bus_oe  = 1'b0;
        endcase
    end
endmodule

// File: rtl/fhr_read_target.sv
// Module: top of the firmware-hub single-byte read target.
// Assumes a synchronous memory that returns data one edge after mem_rd.
module fhr_read_target #(
    parameter int ADDR_W = 28
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       frame_n,
    input  logic [fhr_pkg::NIB_W-1:0]  bus_in,
    output logic [fhr_pkg::NIB_W-1:0]  bus_out,
    output logic                       bus_oe,
    input  logic [fhr_pkg::NIB_W-1:0]  id_strap,
    output logic                       mem_rd,
    output logic [ADDR_W-1:0]          mem_addr,
    input  logic [fhr_pkg::DATA_W-1:0] mem_rdata
);
    import fhr_pkg::*;

    phase_t phase;
    logic   addr_shift_en;
    logic   addr_last;

    fhr_seq seq_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_n       (frame_n),
        .nib           (bus_in),
        .id_strap      (id_strap),
        .addr_last     (addr_last),
        .phase         (phase),
        .addr_shift_en (addr_shift_en)
    );

    fhr_addr_shift #(.ADDR_W(ADDR_W)) addr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (addr_shift_en),
        .nib       (bus_in),
        .addr      (mem_addr),
        .addr_last (addr_last)
    );

    fhr_drive drv_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .mem_rdata (mem_rdata),
        .bus_out   (bus_out),
        .bus_oe    (bus_oe)
    );

    // The read is issued in the first turnaround clock, after the size code.
    assign mem_rd = (phase == PH_HTAR);
endmodule

// File: rtl/fhr_read_target_chk.sv
// Module: protocol assertions for the read target, bound to the top module.
// Assumes the memory model answers one edge after mem_rd.
module fhr_read_target_chk #(
    parameter int ADDR_W = 28
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       frame_n,
    input logic [fhr_pkg::NIB_W-1:0]  bus_in,
    input logic [fhr_pkg::NIB_W-1:0]  bus_out,
    input logic                       bus_oe,
    input logic                       mem_rd,
    input logic [ADDR_W-1:0]          mem_addr,
    input logic [fhr_pkg::DATA_W-1:0] mem_rdata,
    input fhr_pkg::phase_t            phase
);
    import fhr_pkg::*;

    // R7: the clock after the read request, with no restart, drives 1111.
    p_turn_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd && frame_n |=> bus_oe && bus_out == CODE_ONES);

    // R10: a low strobe at an edge leaves the bus released in the next clock.
    p_abort_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |=> !bus_oe && !mem_rd);

    // R5: a read request follows only a size nibble of 0000 sampled with strobe high.
    p_size_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> $past(frame_n && bus_in == CODE_SIZE_ONE));

    // R6: the read request is a single-cycle pulse.
    p_rd_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // R11: drivers turn on only right after a read request.
    p_oe_entry_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |-> $past(mem_rd));

    // R8: the sync clock drives the ready code.
    p_sync_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_SYNC |-> bus_oe && bus_out == CODE_READY);

    // R8: the low data nibble is the one the memory returned two clocks earlier.
    p_data_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_DLO |-> bus_out == $past(mem_rdata[NIB_W-1:0], 2));

    // R4: the address stays put while the data is being returned.
    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_SYNC |-> $stable(mem_addr));
endmodule

bind fhr_read_target fhr_read_target_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_n   (frame_n),
    .bus_in    (bus_in),
    .bus_out   (bus_out),
    .bus_oe    (bus_oe),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .phase     (phase)
);

// File: tb/fhr_read_target_tb_top.sv
// Scoreboard bench: driver tasks push expected per-clock outputs into a queue.
// A monitor pops the queue and compares late in each clock.
module fhr_read_target_tb_top;
    localparam int ADDR_W = 28;
    localparam time TCK   = 20ns;
    localparam int  WD_CYC = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_n = 1'b1;
    logic [3:0]        bus_in = 4'hF;
    logic [3:0]        bus_out;
    logic              bus_oe;
    logic [3:0]        id_strap = 4'hA;
    logic              mem_rd;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_rdata = 8'h00;

    int ecnt = 0;
    int n_total = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        int                due;
        bit                oe;
        logic [3:0]        out;
        bit                rd;
        logic [ADDR_W-1:0] addr;
        string             tag;
    } exp_t;
    exp_t q[$];

    always #(TCK/2) clk = ~clk;

    fhr_read_target #(.ADDR_W(ADDR_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_n   (frame_n),
        .bus_in    (bus_in),
        .bus_out   (bus_out),
        .bus_oe    (bus_oe),
        .id_strap  (id_strap),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata)
    );

    function automatic logic [7:0] mem_f(input logic [ADDR_W-1:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction

    // Memory model: data appears one edge after the request.
    always @(posedge clk) if (mem_rd) mem_rdata <= mem_f(mem_addr);

    always @(posedge clk) ecnt <= ecnt + 1;

    task automatic push(input int due, input bit oe, input logic [3:0] out,
                        input bit rd, input logic [ADDR_W-1:0] a, input string tag);
        exp_t e;
        e.due = due; e.oe = oe; e.out = out; e.rd = rd; e.addr = a; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compares outputs 15 ns after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #15ns;
            while (q.size() > 0 && q[0].due <= ecnt) begin
                exp_t e;
                bit bad;
                e = q.pop_front();
                n_total++;
                bad = (e.due != ecnt) || (bus_oe !== e.oe) || (mem_rd !== e.rd)
                      || (e.oe && bus_out !== e.out) || (e.rd && mem_addr !== e.addr);
                if (bad) begin
                    n_fail++;
                    $display("FAIL %s clk %0d: oe=%b out=%h rd=%b addr=%h expected oe=%b out=%h rd=%b addr=%h",
                             e.tag, e.due, bus_oe, bus_out, mem_rd, mem_addr,
                             e.oe, e.out, e.rd, e.addr);
                end
            end
        end
    end

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_n = 1'b1; bus_in = 4'hF;
            push(ecnt + 1, 1'b0, 4'h0, 1'b0, '0, tag);
        end
    endtask

    // One extra start nibble with the strobe low, ahead of the next transfer.
    task automatic pre_start(input logic [3:0] nib, input string tag);
        @(negedge clk);
        frame_n = 1'b0; bus_in = nib;
        push(ecnt + 1, 1'b0, 4'h0, 1'b0, '0, tag);
    endtask

    // Drives the first ncyc clocks of a read transfer and queues the expectations.
    task automatic read_txn(input logic [3:0] st, input logic [3:0] idv,
                            input logic [ADDR_W-1:0] a, input logic [3:0] sz,
                            input int ncyc, input string tag);
        int base;
        bit ok;
        logic [7:0] d;
        ok = (st == 4'b1101) && (idv == id_strap) && (sz == 4'b0000);
        d  = mem_f(a);
        @(negedge clk);
        base = ecnt;
        for (int i = 1; i <= ncyc; i++) begin
            if (!ok || i < 10 || i > 15)  push(base + i, 1'b0, 4'h0, 1'b0, '0, tag);
            else if (i == 10)             push(base + i, 1'b0, 4'h0, 1'b1, a, tag);
            else if (i == 11)             push(base + i, 1'b1, 4'hF, 1'b0, '0, tag);
            else if (i == 12)             push(base + i, 1'b1, 4'h0, 1'b0, '0, tag);
            else if (i == 13)             push(base + i, 1'b1, d[3:0], 1'b0, '0, tag);
            else if (i == 14)             push(base + i, 1'b1, d[7:4], 1'b0, '0, tag);
            else                          push(base + i, 1'b1, 4'hF, 1'b0, '0, tag);
        end
        for (int i = 1; i <= ncyc; i++) begin
            if (i > 1) @(negedge clk);
            frame_n = (i == 1) ? 1'b0 : 1'b1;
            if (i == 1)       bus_in = st;
            else if (i == 2)  bus_in = idv;
            else if (i <= 9)  bus_in = a[(9-i)*4 +: 4];
            else if (i == 10) bus_in = sz;
            else              bus_in = 4'hF;
        end
    endtask

    initial begin
        #(TCK * WD_CYC);
        if (!finished) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state, outputs quiet
        n_total++;
        if (bus_oe !== 1'b0 || mem_rd !== 1'b0) begin
            n_fail++;
            $display("FAIL R11 reset: oe=%b rd=%b expected oe=0 rd=0", bus_oe, mem_rd);
        end
        rst_n = 1'b1;
        idle(2, "R11 idle");

        // R4 R6 R7 R8 R9: plain reads with varied addresses
        read_txn(4'b1101, 4'hA, 28'h1234567, 4'h0, 17, "R4 R6 R7 R8 R9 read");
        read_txn(4'b1101, 4'hA, 28'hFEDCBA9, 4'h0, 17, "R4 R8 read high addr");
        idle(1, "R9 gap");
        read_txn(4'b1101, 4'hA, 28'h0000000, 4'h0, 17, "R8 read zero addr");

        // R2: wrong start code
        read_txn(4'b1100, 4'hA, 28'h0ABCDEF, 4'h0, 17, "R2 bad start");
        // R3: ID mismatch
        read_txn(4'b1101, 4'h5, 28'h0ABCDEF, 4'h0, 17, "R3 id mismatch");
        // R5: non-single size code
        read_txn(4'b1101, 4'hA, 28'h0ABCDEF, 4'h1, 17, "R5 size 0001");
        read_txn(4'b1101, 4'hA, 28'h0ABCDEF, 4'hF, 17, "R5 size 1111");

        // R1: repeated start nibbles, the last one counts
        pre_start(4'b1101, "R1 pre");
        read_txn(4'b1101, 4'hA, 28'h1357BDF, 4'h0, 17, "R1 double start");
        pre_start(4'b1101, "R1 pre");
        read_txn(4'b0101, 4'hA, 28'h1357BDF, 4'h0, 17, "R1 cancelled start");
        pre_start(4'b0000, "R1 pre");
        read_txn(4'b1101, 4'hA, 28'h2468ACE, 4'h0, 17, "R1 late start");

        // R10: strobe reasserted mid-cycle at several points
        read_txn(4'b1101, 4'hA, 28'h1111111, 4'h0, 6, "R10 cut in addr");
        read_txn(4'b1101, 4'hA, 28'h2222222, 4'h0, 17, "R10 after addr cut");
        read_txn(4'b1101, 4'hA, 28'h3333333, 4'h0, 13, "R10 cut in data");
        read_txn(4'b1101, 4'hA, 28'h4444444, 4'h0, 17, "R10 after data cut");
        read_txn(4'b1101, 4'hA, 28'h5555555, 4'h0, 15, "R10 cut at end");
        read_txn(4'b1101, 4'hA, 28'h6666666, 4'h0, 17, "R10 after end cut");

        // R3: a different strap value
        idle(1, "R3 strap change");
        id_strap = 4'h3;
        read_txn(4'b1101, 4'h3, 28'h789ABCD, 4'h0, 17, "R3 strap 3");
        read_txn(4'b1101, 4'hA, 28'h789ABCD, 4'h0, 17, "R3 old id ignored");
        idle(3, "R11 tail");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule